// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that lets a host processor read and write a bank of byte-wide configuration registers. A transfer is framed by an active-low select line. Each transfer carries sixteen serial clock bits: an instruction byte that names the register and the direction, then one data byte. The contents of every register are driven out in parallel, so neighbouring logic can decode its own control fields straight from the flat vector.

Register 0 controls the port itself. Its top bit chooses where read data leaves: on the shared data pin (3-wire) or on the separate output pin (4-wire). The next bit chooses whether both bytes travel least-significant bit first. The bit below that is a soft reset that puts every register back to its default. The port samples the select, clock and data pins into a faster system clock. The serial clock must therefore run at no more than about one sixth of the system clock rate.

Top module: `spi_cfg_port`

## Requirements
- R1: After the synchronous reset, every register holds 0x00 except register 2, which holds 0x02. Registers 2 and 3 together form the 10-bit full-scale code: bits 1:0 of register 2 are code bits 9:8 and register 3 is code bits 7:0. The default code is therefore 0x200. Both output enables are low.
- R2: While the select line is high, neither `spi_sdio_oe` nor `spi_sdo_oe` is asserted.
- R3: Input bits are sampled on rising serial clock edges. The first eight form the instruction and the next eight form the data. In the instruction, bit 7 = 1 means read, bits 4:0 are the address and bits 6:5 are ignored. A write takes effect once the sixteenth rising edge has been seen.
- R4: On a read, the output enable rises after the eighth rising edge. The first data bit appears on the falling edge that follows it, and each later bit changes only on a falling edge.
- R5: When register 0 bit 7 is 1, read data leaves on `spi_sdio_o` with `spi_sdio_oe` high. When it is 0, read data leaves on `spi_sdo_o` with `spi_sdo_oe` high. The two enables are never high together.
- R6: When register 0 bit 6 is 1, both bytes are sent and received LSB first. When it is 0, both are MSB first. A new setting applies from the next transfer.
- R7: Writing register 0 with bit 5 set returns every register, register 0 included, to its R1 default.
- R8: Every register at addresses 0 to 22 reads back the last 8-bit value written to it. A write to addresses 23 to 31 changes no register, and a read from those addresses returns 0x00.
- R9: If the select line rises before the sixteenth rising edge, the transfer is dropped and no register changes.
- R10: `cfg_flat` bits [8n+7:8n] always carry register n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csn | input | 1 | Active-low transfer select |
| spi_sclk | input | 1 | Serial clock |
| spi_sdio_i | input | 1 | Serial data in (receive side of the shared data pin) |
| spi_sdio_o | output | 1 | Read data for the shared data pin |
| spi_sdio_oe | output | 1 | Drive enable for the shared data pin |
| spi_sdo_o | output | 1 | Read data for the separate output pin |
| spi_sdo_oe | output | 1 | Drive enable for the separate output pin |
| cfg_flat | output | NUM_REGS*8 | All registers side by side, register n in bits [8n+7:8n] |

## Verification
The hardest states to reach are a transfer cut short by the select line, and a transfer that runs straight after register 0 has changed the bit order or the output pin. A bench that always uses one framing never gets there. The random sequence writes register 0 often, with the soft-reset bit held rare. Its own model tracks the current mode so that every following transfer is encoded and decoded the same way the port expects. Directed cases then abort writes after a few bits and at fifteen bits, and write and read beyond address 22.

// File: rtl/spi_cfg_pkg.sv
// Shared constants for the serial configuration port: register count,
// control-bit positions in register 0 and per-register reset values.
package spi_cfg_pkg;

    localparam int CFG_NUM_REGS   = 23;
    localparam int CFG_ADDR_W     = 5;
    localparam int MODE_DIR_BIT   = 7;   // 1: read data on shared pin
    localparam int MODE_LSB_BIT   = 6;   // 1: LSB first
    localparam int MODE_SRST_BIT  = 5;   // 1: soft reset on write
    localparam int FS_HI_ADDR     = 2;   // full-scale code bits 9:8
    localparam int FS_LO_ADDR     = 3;   // full-scale code bits 7:0
    localparam logic [9:0] FS_DEFAULT = 10'h200;

    // Reset value of register idx.
    function automatic logic [7:0] cfg_default(input int idx);
        if (idx == FS_HI_ADDR)      return {6'd0, FS_DEFAULT[9:8]};
        else if (idx == FS_LO_ADDR) return FS_DEFAULT[7:0];
        else                        return 8'h00;
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
// Multi-stage synchronizer for asynchronous serial pins.
// Assumes each input stays stable for several system clocks.
module spi_in_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift the pin values one stage further into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= RESET_VAL;
            else if (s == 0) stage_q[s] <= d_i;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_cfg_shifter.sv
// Serial frame engine: counts clock edges, assembles instruction and
// data bytes in the selected bit order, issues a write strobe after a
// complete frame and shifts read data out on falling edges.
// Assumes edge pulses are one system clock wide and already synchronized.
module spi_cfg_shifter #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi,
    input  logic              lsb_first,
    input  logic [7:0]        rd_byte,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              out_en,
    output logic              dout
);
    localparam int BYTE_BITS  = 8;
    localparam int FRAME_BITS = 2 * BYTE_BITS;
    localparam int CW         = $clog2(FRAME_BITS + 1);
    localparam logic [CW-1:0] CNT_FULL  = CW'(FRAME_BITS);
    localparam logic [CW-1:0] CNT_LAST  = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] CNT_INSTR = CW'(BYTE_BITS - 1);
    localparam logic [CW-1:0] CNT_BYTE  = CW'(BYTE_BITS);

    logic [CW-1:0] cnt_q;
    logic [7:0]    instr_q;
    logic [7:0]    data_q;
    logic [2:0]    in_pos;
    logic [2:0]    out_pos;
    logic          rd_now;

    // Bit position addressed by the current edge in the selected order.
    assign in_pos  = lsb_first ? cnt_q[2:0] : ~cnt_q[2:0];
    assign out_pos = lsb_first ? cnt_q[2:0] : ~cnt_q[2:0];
    // Read flag including a bit that arrives on this very edge.
    assign rd_now  = (in_pos == 3'd7) ? sdi : instr_q[7];

    // Frame counter, byte assembly, write strobe and output shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            instr_q <= '0;
            data_q  <= '0;
            wr_stb  <= 1'b0;
            out_en  <= 1'b0;
            dout    <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (!cs_act) begin
                cnt_q  <= '0;
                out_en <= 1'b0;
            end else begin
                if (sclk_rise && cnt_q < CNT_FULL) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q < CNT_BYTE) instr_q[in_pos] <= sdi;
                    else                  data_q[in_pos]  <= sdi;
                    if (cnt_q == CNT_INSTR) out_en <= rd_now;
                    if (cnt_q == CNT_LAST)  wr_stb <= ~instr_q[7];
                end
                if (sclk_fall && out_en && cnt_q >= CNT_BYTE && cnt_q < CNT_FULL)
                    dout <= rd_byte[out_pos];
            end
        end
    end

    assign rd_addr = instr_q[ADDR_W-1:0];
    assign wr_addr = instr_q[ADDR_W-1:0];
    assign wr_data = data_q;

    // R2
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !out_en);
    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL);
    // R4
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(dout));
    // R9
    wr_full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> cnt_q == CNT_FULL);
endmodule

// File: rtl/spi_cfg_regbank.sv
// Byte-wide register bank with per-register defaults, a soft reset
// triggered through register 0 and a read multiplexer.
// Assumes at most one write strobe per transfer.
module spi_cfg_regbank
    import spi_cfg_pkg::*;
#(
    parameter int NUM_REGS = CFG_NUM_REGS,
    parameter int ADDR_W   = CFG_ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] cfg_flat
);
    logic [7:0]            regs_q [NUM_REGS];
    logic [NUM_REGS*8-1:0] dflt_flat;
    logic                  soft_rst;

    assign soft_rst = wr_en && (wr_addr == '0) && wr_data[MODE_SRST_BIT];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [7:0] DFLT = cfg_default(i);
        // Hold register i: default on reset or soft reset, else take writes.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst)                        regs_q[i] <= DFLT;
            else if (wr_en && wr_addr == ADDR_W'(i))       regs_q[i] <= wr_data;
        end
        assign cfg_flat[i*8 +: 8]  = regs_q[i];
        assign dflt_flat[i*8 +: 8] = DFLT;
    end

    // Select the addressed register; out-of-range reads return zero.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = regs_q[i];
    end

    // R7
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> cfg_flat == dflt_flat);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_flat));
    // R8
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_W'(NUM_REGS)) |=> $stable(cfg_flat));
endmodule

// File: rtl/spi_cfg_port.sv
// Top of the serial configuration port. Synchronizes the serial pins,
// derives clock edges, and routes read data to the pin chosen by
// register 0. Assumes the serial clock is at most clk/6.
module spi_cfg_port
    import spi_cfg_pkg::*;
#(
    parameter int NUM_REGS    = CFG_NUM_REGS,
    parameter int ADDR_W      = CFG_ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_csn,
    input  logic                  spi_sclk,
    input  logic                  spi_sdio_i,
    output logic                  spi_sdio_o,
    output logic                  spi_sdio_oe,
    output logic                  spi_sdo_o,
    output logic                  spi_sdo_oe,
    output logic [NUM_REGS*8-1:0] cfg_flat
);
    logic [2:0]        pins_s;
    logic              csn_s, sclk_s, sdi_s, sclk_prev;
    logic              sclk_rise, sclk_fall, cs_act;
    logic              out_en, dout, wr_stb;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [7:0]        wr_data, rd_byte;
    logic              mode_dir, mode_lsb;

    spi_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({spi_csn, spi_sclk, spi_sdio_i}),
        .q_o   (pins_s)
    );
    assign {csn_s, sclk_s, sdi_s} = pins_s;

    // Remember the previous synchronized serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    assign cs_act    = ~csn_s;
    assign sclk_rise = sclk_s & ~sclk_prev;
    assign sclk_fall = ~sclk_s & sclk_prev;
    assign mode_dir  = cfg_flat[MODE_DIR_BIT];
    assign mode_lsb  = cfg_flat[MODE_LSB_BIT];

    spi_cfg_shifter #(.ADDR_W(ADDR_W)) i_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi       (sdi_s),
        .lsb_first (mode_lsb),
        .rd_byte   (rd_byte),
        .rd_addr   (rd_addr),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .out_en    (out_en),
        .dout      (dout)
    );

    spi_cfg_regbank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) i_regbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_byte),
        .cfg_flat (cfg_flat)
    );

    assign spi_sdio_o  = dout;
    assign spi_sdo_o   = dout;
    assign spi_sdio_oe = out_en & mode_dir;
    assign spi_sdo_oe  = out_en & ~mode_dir;

    // R5
    oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({spi_sdio_oe, spi_sdo_oe}));
    // R2
    oe_csn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csn_s) |=> !(spi_sdio_oe || spi_sdo_oe));
endmodule

// File: tb/test_spi_cfg_port.sv
module test_spi_cfg_port;
    localparam int NR = 23;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_csn = 1'b1, spi_sclk = 1'b0, spi_sdio_i = 1'b0;
    logic spi_sdio_o, spi_sdio_oe, spi_sdo_o, spi_sdo_oe;
    logic [NR*8-1:0] cfg_flat;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] exp_q [NR];
    logic [7:0] rd_val;
    bit         oe_good;

    always #10 clk = ~clk;

    spi_cfg_port i_spi_cfg_port (
        .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
        .spi_sdio_i(spi_sdio_i), .spi_sdio_o(spi_sdio_o), .spi_sdio_oe(spi_sdio_oe),
        .spi_sdo_o(spi_sdo_o), .spi_sdo_oe(spi_sdo_oe), .cfg_flat(cfg_flat)
    );

    function automatic logic [7:0] dflt(input int i);
        return (i == 2) ? 8'h02 : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NR; i++) exp_q[i] = dflt(i);
    endtask

    // R10 / R8: compare every register slice with the model.
    task automatic check_regs(input string req);
        bit ok = 1'b1;
        int bad = 0;
        for (int i = 0; i < NR; i++)
            if (cfg_flat[i*8 +: 8] !== exp_q[i]) begin ok = 1'b0; bad = i; end
        chk(ok, req, {bad[7:0], 16'd0, cfg_flat[bad*8 +: 8]}, {bad[7:0], 16'd0, exp_q[bad]});
    endtask

    // One transfer; stop_after < 16 drops select early.
    task automatic xfer(input bit rd, input logic [4:0] a, input logic [7:0] wd,
                        input int stop_after, output logic [7:0] rv, output bit oe_ok);
        logic [7:0] ins = {rd, 2'b00, a};
        bit lsb = exp_q[0][6];
        bit dir = exp_q[0][7];
        int done = 0;
        rv = 8'h00;
        oe_ok = 1'b1;
        @(negedge clk) spi_csn = 1'b0;
        for (int k = 0; k < 16; k++) begin
            int p = lsb ? (k % 8) : 7 - (k % 8);
            spi_sdio_i = (k < 8) ? ins[p] : (rd ? 1'b0 : wd[p]);
            repeat (HALF) @(negedge clk);
            if (k >= 8 && rd) begin
                rv[p] = dir ? spi_sdio_o : spi_sdo_o;
                if (spi_sdio_oe !== dir || spi_sdo_oe !== !dir) oe_ok = 1'b0;
            end
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
            done = k + 1;
            if (done == stop_after) break;
        end
        repeat (HALF) @(negedge clk);
        spi_csn = 1'b1;
        repeat (HALF) @(negedge clk);
        if (done == 16 && !rd && a < 5'(NR)) begin
            if (a == 0 && wd[5]) model_reset();
            else exp_q[a] = wd;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_regs("R1 reset defaults");
        chk(!spi_sdio_oe && !spi_sdo_oe, "R1 R2 idle enables", {spi_sdio_oe, spi_sdo_oe}, 0);

        // R3 / R8 basic write then read in 4-wire MSB-first.
        xfer(1'b0, 5'd5, 8'hA5, 16, rd_val, oe_good);
        check_regs("R3 write");
        xfer(1'b1, 5'd5, 8'h00, 16, rd_val, oe_good);
        chk(rd_val == 8'hA5, "R4 R8 read back", rd_val, 8'hA5);
        chk(oe_good, "R5 4-wire pin", oe_good, 1);
        chk(!spi_sdio_oe && !spi_sdo_oe, "R2 enables after frame", {spi_sdio_oe, spi_sdo_oe}, 0);
        xfer(1'b1, 5'd2, 8'h00, 16, rd_val, oe_good);
        chk(rd_val == 8'h02, "R1 full-scale high byte", rd_val, 8'h02);

        // R9 aborted writes.
        xfer(1'b0, 5'd7, 8'h3C, 12, rd_val, oe_good);
        check_regs("R9 abort at 12");
        xfer(1'b0, 5'd7, 8'h3C, 15, rd_val, oe_good);
        check_regs("R9 abort at 15");

        // R8 out-of-range addresses.
        xfer(1'b0, 5'd23, 8'hFF, 16, rd_val, oe_good);
        check_regs("R8 write addr 23 ignored");
        xfer(1'b0, 5'd31, 8'h77, 16, rd_val, oe_good);
        check_regs("R8 write addr 31 ignored");
        xfer(1'b1, 5'd30, 8'h00, 16, rd_val, oe_good);
        chk(rd_val == 8'h00, "R8 read out of range", rd_val, 0);

        // R5 / R6 3-wire LSB-first.
        xfer(1'b0, 5'd0, 8'hC0, 16, rd_val, oe_good);
        check_regs("R6 mode write");
        xfer(1'b0, 5'd22, 8'h1E, 16, rd_val, oe_good);
        check_regs("R6 LSB-first write");
        xfer(1'b1, 5'd22, 8'h00, 16, rd_val, oe_good);
        chk(rd_val == 8'h1E, "R6 LSB-first read", rd_val, 8'h1E);
        chk(oe_good, "R5 3-wire pin", oe_good, 1);
        xfer(1'b1, 5'd0, 8'h00, 16, rd_val, oe_good);
        chk(rd_val == 8'hC0, "R6 mode readback", rd_val, 8'hC0);

        // R7 soft reset.
        xfer(1'b0, 5'd3, 8'h99, 16, rd_val, oe_good);
        xfer(1'b0, 5'd0, 8'hE0, 16, rd_val, oe_good);
        check_regs("R7 soft reset");
        xfer(1'b1, 5'd3, 8'h00, 16, rd_val, oe_good);
        chk(rd_val == 8'h00, "R7 full-scale low byte default", rd_val, 8'h00);

        // Random mix.
        for (int t = 0; t < 150; t++) begin
            bit rd = $urandom_range(1, 0) == 1;
            logic [4:0] a = 5'($urandom_range(31, 0));
            logic [7:0] d = 8'($urandom);
            int stop = ($urandom_range(9, 0) == 0) ? $urandom_range(15, 1) : 16;
            logic [7:0] ev;
            if (($urandom_range(3, 0) == 0)) a = 5'd0;
            if (a == 0 && $urandom_range(7, 0) != 0) d[5] = 1'b0;
            ev = (a < 5'(NR)) ? exp_q[a] : 8'h00;
            xfer(rd, a, d, stop, rd_val, oe_good);
            if (rd && stop == 16) begin
                chk(rd_val == ev, "R4 R6 R8 random read", rd_val, ev);
                chk(oe_good, "R5 random read pin", oe_good, 1);
            end else begin
                check_regs("R3 R9 R10 random write");
            end
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule